// File: doc/BRIEF.md
# Package Idle-State Resolver with Shared-Cache Flush Sequencer

This block turns the idle states granted to each core into one package idle state. The package follows the shallowest core. A platform input sets the deepest package state the platform allows, and the package output never goes deeper than that value. The output moves straight from one idle state to another and does not pass through the active state on the way.

The deepest state needs extra work first. When the last core reaches C7 and the platform allows C7, the block asks a cache controller to flush the shared cache. The core that arrived last is the owner of the flush, and its substate hint picks the flush style. With the hint set, one request flushes the whole cache. Without it, the block sends one request per way group, in a fixed order. Each request stays asserted until the controller returns a done pulse. While a flush runs, the package shows C6. C7 is shown only after the last done. If any core leaves C7, or the platform withdraws permission, the flush stops at once and the package follows its inputs again.

State codes on every state port: 0 = C0, 1 = C1/C1E, 2 = C3, 3 = C6, 4 = C7. A larger code means a deeper state. Codes above 4 are read as C7.

Top module: `cst_pkg_resolver`

## Requirements
- R1: When the flush logic is not involved, `pkg_state` equals the smallest code among the cores.
- R2: `pkg_state` never exceeds `plat_limit`. The output is the smaller of the core minimum and `plat_limit`.
- R3: `pkg_state` is registered. A change on the inputs shows on the output one clock edge later. After reset the output is C0 (code 0) and `flush_req` is 0.
- R4: The package can move straight from one idle state to another, for example from C3 (2) to C6 (3), with no C0 cycle between them.
- R5: A flush starts only in the cycle after every core shows C7 and `plat_limit` allows C7. From that edge `flush_req` is 1 and `pkg_state` shows C6 (3).
- R6: `flush_owner` gives the index of the core that reached C7 last. If several cores arrive in the same cycle, the lowest index among them is used.
- R7: If the owner's `core_hint` bit is 1, one request with `flush_full`=1 is sent. Its done pulse ends the flush. The hint bits of other cores have no effect.
- R8: If the owner's hint bit is 0, the block sends way-group requests with `flush_group` = 0, 1, 2, 3 in that order. Each request holds its group until a done pulse is seen. The next group follows on the next edge.
- R9: `pkg_state` becomes C7 only on the edge after the last done pulse of the flush.
- R10: If the core minimum or `plat_limit` drops below C7 during a flush, `flush_req` falls on the next edge and `pkg_state` takes the capped minimum, for example C0 when a core returns to C0.
- R11: A done pulse has no effect while no request is pending.
- R12: After a flush completes, the block sends no new request while every core stays in C7. A new flush starts only after the package has left C7 and entered it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| core_state | input | NCORES*3 | Granted idle-state code per core; core i is in bits [3i+2:3i] |
| core_hint | input | NCORES | Per-core substate hint asking for a full flush in one step |
| plat_limit | input | 3 | Deepest package state the platform allows |
| flush_done | input | 1 | One-cycle pulse from the cache controller that completes the pending request |
| pkg_state | output | 3 | Resolved package idle-state code |
| flush_req | output | 1 | Flush request, held until done or abort |
| flush_full | output | 1 | 1 = whole-cache flush, 0 = way-group flush |
| flush_group | output | GW | Way group of the pending request |
| flush_owner | output | IDW | Index of the core that owns the flush |

## Verification
Every result is due exactly one edge after the stimulus that causes it. This covers the capped minimum, the start of a flush, a step to the next group, completion to C7 and an abort. The bench changes inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. In the sweep, each input pattern is held for exactly one cycle, and its expected output is checked before the next pattern is applied. In the flush scenarios the bench first holds a request across extra edges with no done, to show that nothing advances. It then checks the state one edge after each done pulse.

// File: rtl/cst_pkg.sv
package cst_pkg;
  localparam int ST_W = 3;
  typedef logic [ST_W-1:0] cst_t;

  localparam cst_t CS_C0 = 3'd0;
  localparam cst_t CS_C1 = 3'd1;
  localparam cst_t CS_C3 = 3'd2;
  localparam cst_t CS_C6 = 3'd3;
  localparam cst_t CS_C7 = 3'd4;

  typedef enum logic [1:0] {SQ_IDLE = 2'd0, SQ_FLUSH = 2'd1, SQ_DONE = 2'd2} seq_e;

  // Codes past the deepest state saturate to it.
  function automatic cst_t cst_sat(input cst_t c);
    return (c > CS_C7) ? CS_C7 : c;
  endfunction

  // The shallower of two states is the numerically smaller code.
  function automatic cst_t cst_shallow(input cst_t a, input cst_t b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/cst_min_chain.sv
module cst_min_chain
  import cst_pkg::*;
#(
  parameter int NCORES = 4
) (
  input  logic [NCORES*ST_W-1:0] core_state,
  output cst_t                   core_min,
  output logic [NCORES-1:0]      in_c7
);
  cst_t stage [NCORES+1];
  assign stage[0] = CS_C7;

  for (genvar i = 0; i < NCORES; i++) begin : g_core
    cst_t s;
    assign s          = cst_sat(core_state[i*ST_W +: ST_W]);
    assign stage[i+1] = cst_shallow(stage[i], s);
    assign in_c7[i]   = (s == CS_C7);
  end

  assign core_min = stage[NCORES];
endmodule

// File: rtl/cst_entrant.sv
module cst_entrant
  import cst_pkg::*;
#(
  parameter int NCORES = 4,
  localparam int IDW = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCORES-1:0] in_c7,
  input  logic [NCORES-1:0] core_hint,
  output logic [IDW-1:0]    owner_sel,
  output logic              hint_sel
);
  logic [NCORES-1:0] prev_c7_q;
  logic [NCORES-1:0] fresh;
  logic [IDW-1:0]    last_q;
  logic [IDW-1:0]    pick;

  assign fresh = in_c7 & ~prev_c7_q;

  // Lowest-index newcomer wins a tie.
  always_comb begin
    pick = last_q;
    for (int i = NCORES - 1; i >= 0; i--) begin
      if (fresh[i]) pick = IDW'(i);
    end
  end

  assign owner_sel = pick;
  assign hint_sel  = core_hint[pick];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_c7_q <= '0;
      last_q    <= '0;
    end else begin
      prev_c7_q <= in_c7;
      last_q    <= pick;
    end
  end
endmodule

// File: rtl/cst_flush_seq.sv
module cst_flush_seq
  import cst_pkg::*;
#(
  parameter int NGRP = 4,
  parameter int IDW  = 2,
  localparam int GW  = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  cst_t           target,
  input  logic [IDW-1:0] owner_sel,
  input  logic           hint_sel,
  input  logic           flush_done,
  output cst_t           pkg_state,
  output logic           flush_req,
  output logic           flush_full,
  output logic [GW-1:0]  flush_group,
  output logic [IDW-1:0] flush_owner,
  output logic           ev_start,
  output logic           ev_abort,
  output logic           ev_finish
);
  localparam logic [GW-1:0] LAST_GRP = GW'(NGRP - 1);

  seq_e           st_q, st_n;
  logic           full_q, full_n;
  logic [GW-1:0]  grp_q, grp_n;
  logic [IDW-1:0] own_q, own_n;
  cst_t           pkg_q, pkg_n;
  logic           eligible;
  logic           final_step;

  assign eligible   = (target == CS_C7);
  assign final_step = full_q || (grp_q == LAST_GRP);

  assign ev_start  = (st_q == SQ_IDLE)  && eligible;
  assign ev_abort  = (st_q == SQ_FLUSH) && !eligible;
  assign ev_finish = (st_q == SQ_FLUSH) && eligible && flush_done && final_step;

  always_comb begin
    st_n   = st_q;
    full_n = full_q;
    grp_n  = grp_q;
    own_n  = own_q;
    unique case (st_q)
      SQ_IDLE: if (ev_start) begin
        st_n   = SQ_FLUSH;
        full_n = hint_sel;
        grp_n  = '0;
        own_n  = owner_sel;
      end
      SQ_FLUSH: begin
        if (ev_abort)            st_n  = SQ_IDLE;
        else if (ev_finish)      st_n  = SQ_DONE;
        else if (flush_done)     grp_n = grp_q + 1'b1;
      end
      SQ_DONE: if (!eligible) st_n = SQ_IDLE;
      default: st_n = SQ_IDLE;
    endcase
    if (!eligible)             pkg_n = target;
    else if (st_n == SQ_DONE)  pkg_n = CS_C7;
    else                       pkg_n = CS_C6;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SQ_IDLE;
      full_q <= 1'b0;
      grp_q  <= '0;
      own_q  <= '0;
      pkg_q  <= CS_C0;
    end else begin
      st_q   <= st_n;
      full_q <= full_n;
      grp_q  <= grp_n;
      own_q  <= own_n;
      pkg_q  <= pkg_n;
    end
  end

  assign pkg_state   = pkg_q;
  assign flush_req   = (st_q == SQ_FLUSH);
  assign flush_full  = full_q;
  assign flush_group = grp_q;
  assign flush_owner = own_q;
endmodule

// File: rtl/cst_pkg_resolver.sv
module cst_pkg_resolver
  import cst_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int NGRP   = 4,
  localparam int IDW   = (NCORES > 1) ? $clog2(NCORES) : 1,
  localparam int GW    = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCORES*ST_W-1:0] core_state,
  input  logic [NCORES-1:0]      core_hint,
  input  logic [ST_W-1:0]        plat_limit,
  input  logic                   flush_done,
  output logic [ST_W-1:0]        pkg_state,
  output logic                   flush_req,
  output logic                   flush_full,
  output logic [GW-1:0]          flush_group,
  output logic [IDW-1:0]         flush_owner
);
  cst_t              core_min;
  cst_t              lim_sat;
  cst_t              target;
  logic [NCORES-1:0] in_c7;
  logic [IDW-1:0]    owner_sel;
  logic              hint_sel;
  logic              ev_start, ev_abort, ev_finish;

  cst_min_chain #(.NCORES(NCORES)) u_min (
    .core_state(core_state),
    .core_min  (core_min),
    .in_c7     (in_c7)
  );

  assign lim_sat = cst_sat(plat_limit);
  assign target  = cst_shallow(core_min, lim_sat);

  cst_entrant #(.NCORES(NCORES)) u_ent (
    .clk      (clk),
    .rst      (rst),
    .in_c7    (in_c7),
    .core_hint(core_hint),
    .owner_sel(owner_sel),
    .hint_sel (hint_sel)
  );

  cst_flush_seq #(.NGRP(NGRP), .IDW(IDW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .target     (target),
    .owner_sel  (owner_sel),
    .hint_sel   (hint_sel),
    .flush_done (flush_done),
    .pkg_state  (pkg_state),
    .flush_req  (flush_req),
    .flush_full (flush_full),
    .flush_group(flush_group),
    .flush_owner(flush_owner),
    .ev_start   (ev_start),
    .ev_abort   (ev_abort),
    .ev_finish  (ev_finish)
  );
endmodule

// File: rtl/cst_pkg_resolver_chk.sv
module cst_pkg_resolver_chk
  import cst_pkg::*;
#(
  parameter int GW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    pkg_state,
  input logic          flush_req,
  input logic          flush_full,
  input logic [GW-1:0] flush_group,
  input logic          flush_done,
  input logic [2:0]    target,
  input logic [2:0]    lim_sat
);
  assert_follow_target_R3: assert property (@(posedge clk) disable iff (rst)
    (target != CS_C7) |=> (pkg_state == $past(target)));

  assert_platform_cap_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pkg_state <= $past(lim_sat)));

  assert_drop_on_leave_R10: assert property (@(posedge clk) disable iff (rst)
    (target != CS_C7) |=> !flush_req);

  assert_group_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (flush_req && !flush_done && target == CS_C7) |=> (flush_req && $stable(flush_group)));

  assert_full_single_R7: assert property (@(posedge clk) disable iff (rst)
    (flush_req && flush_full && flush_done && target == CS_C7) |=> (!flush_req && pkg_state == CS_C7));

  assert_c7_after_done_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(pkg_state == CS_C7) |-> $past(flush_done));

  assert_no_refire_R12: assert property (@(posedge clk) disable iff (rst)
    (pkg_state == CS_C7 && target == CS_C7) |=> !flush_req);
endmodule

bind cst_pkg_resolver cst_pkg_resolver_chk #(.GW(GW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pkg_state  (pkg_state),
  .flush_req  (flush_req),
  .flush_full (flush_full),
  .flush_group(flush_group),
  .flush_done (flush_done),
  .target     (target),
  .lim_sat    (lim_sat)
);

// File: tb/tb_cst_pkg_resolver.sv
module tb_cst_pkg_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [11:0]   core_state = '0;
  logic [3:0]    core_hint = '0;
  logic [2:0]    plat_limit = 3'd4;
  logic          flush_done = 1'b0;
  logic [2:0]    pkg_state;
  logic          flush_req, flush_full;
  logic [1:0]    flush_group;
  logic [1:0]    flush_owner;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cst_pkg_resolver dut (
    .clk(clk), .rst(rst), .core_state(core_state), .core_hint(core_hint),
    .plat_limit(plat_limit), .flush_done(flush_done), .pkg_state(pkg_state),
    .flush_req(flush_req), .flush_full(flush_full), .flush_group(flush_group),
    .flush_owner(flush_owner)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setc(input int s0, input int s1, input int s2, input int s3, input int lim);
    core_state = {3'(s3), 3'(s2), 3'(s1), 3'(s0)};
    plat_limit = 3'(lim);
    step();
  endtask

  task automatic pulse_done();
    flush_done = 1'b1;
    step();
    flush_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    eq("R3 reset pkg", pkg_state, 0);
    eq("R3 reset req", flush_req, 0);

    // Sweep: every core code combination under every platform limit.
    for (int k = 0; k < 3125; k++) begin
      int d[NC];
      int lim, mn, exp_pkg;
      int r;
      r = k;
      for (int i = 0; i < NC; i++) begin d[i] = r % 5; r = r / 5; end
      lim = r % 5;
      mn = 4;
      for (int i = 0; i < NC; i++) if (d[i] < mn) mn = d[i];
      exp_pkg = (lim < mn) ? lim : mn;
      setc(d[0], d[1], d[2], d[3], lim);
      if (exp_pkg == 4) begin
        eq("R5 sweep start shows C6", pkg_state, 3);
        eq("R5 sweep start req", flush_req, 1);
      end else begin
        eq("R1 R2 sweep capped minimum", pkg_state, exp_pkg);
        eq("R10 sweep no req", flush_req, 0);
      end
    end

    // R4: direct idle-to-idle moves.
    setc(2, 2, 2, 2, 4);
    eq("R4 at C3", pkg_state, 2);
    setc(3, 3, 3, 3, 4);
    eq("R4 C3 to C6 direct", pkg_state, 3);
    setc(1, 3, 3, 3, 4);
    eq("R4 C6 to C1 direct", pkg_state, 1);

    // R6: owner is the last core in; R8: ordered group flush.
    setc(0, 0, 0, 0, 4);
    setc(4, 0, 0, 0, 4);
    setc(4, 4, 0, 0, 4);
    setc(4, 4, 4, 0, 4);
    eq("R5 not all C7 no req", flush_req, 0);
    core_hint = 4'b0001;
    setc(4, 4, 4, 4, 4);
    eq("R5 start req", flush_req, 1);
    eq("R5 start pkg C6", pkg_state, 3);
    eq("R6 owner last core", flush_owner, 3);
    eq("R7 non-owner hint ignored", flush_full, 0);
    eq("R8 first group", flush_group, 0);
    step(); step();
    eq("R8 group held without done", flush_group, 0);
    eq("R8 req held without done", flush_req, 1);
    for (int g = 1; g < 4; g++) begin
      pulse_done();
      eq("R8 next group", flush_group, g);
      eq("R9 not C7 mid flush", pkg_state, 3);
    end
    pulse_done();
    eq("R9 C7 after last done", pkg_state, 4);
    eq("R9 req released", flush_req, 0);
    step(); step();
    eq("R12 no reflush req", flush_req, 0);
    eq("R12 stays C7", pkg_state, 4);
    pulse_done();
    eq("R11 stray done pkg", pkg_state, 4);
    eq("R11 stray done req", flush_req, 0);

    // R7: owner hint selects full flush; R12 reflush after leaving.
    core_hint = 4'b0100;
    setc(4, 4, 2, 4, 4);
    eq("R12 left C7", pkg_state, 2);
    setc(4, 4, 4, 4, 4);
    eq("R12 reflush req", flush_req, 1);
    eq("R6 owner re-entrant core", flush_owner, 2);
    eq("R7 full flush", flush_full, 1);
    pulse_done();
    eq("R7 single step C7", pkg_state, 4);
    eq("R7 single step req off", flush_req, 0);

    // R10: core returns to C0 mid flush; simultaneous entry owner.
    core_hint = 4'b0000;
    setc(0, 0, 0, 0, 4);
    setc(4, 4, 0, 0, 4);
    setc(4, 4, 4, 4, 4);
    eq("R6 simultaneous lowest index", flush_owner, 2);
    eq("R8 multi-step mode", flush_full, 0);
    pulse_done();
    eq("R8 second group", flush_group, 1);
    setc(4, 0, 4, 4, 4);
    eq("R10 abort req off", flush_req, 0);
    eq("R10 abort pkg C0", pkg_state, 0);
    pulse_done();
    eq("R11 done after abort pkg", pkg_state, 0);
    eq("R11 done after abort req", flush_req, 0);

    // R10: platform withdraws permission mid flush.
    setc(4, 4, 4, 4, 4);
    eq("R5 restart req", flush_req, 1);
    eq("R6 owner core1", flush_owner, 1);
    setc(4, 4, 4, 4, 2);
    eq("R10 platform abort req", flush_req, 0);
    eq("R10 platform abort pkg", pkg_state, 2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule